// File: doc/BRIEF.md
# Sequencer Return and Context Stacks

This block holds two hardware last-in-first-out stores for a small processor's program sequencer. The return-address store keeps 14-bit program addresses. The context store keeps one combined word per interrupt level. That word holds the 8-bit arithmetic flags, the 7-bit mode word and the 10-bit interrupt enable mask. Four event strobes drive both stores: subroutine call, interrupt entry, subroutine return and interrupt return.

A call pushes only the return address. An interrupt entry pushes the return address and the context word together. A subroutine return pops only the return address. An interrupt return pops both. Popped values appear on registered outputs one clock after the pop strobe and hold until the next pop of the same store. A read-only status byte reports, for each store, whether it is empty and whether a push was ever lost to a full store.

Top module: `seq_return_stacks`

## Requirements
- R1: A call or interrupt-entry strobe pushes `pc_i`. A return or interrupt-return strobe pops the most recently pushed address onto `ret_pc_o`, one clock after the strobe, in last-in-first-out order.
- R2: An interrupt-entry strobe pushes `arith_i`, `mode_i` and `mask_i` as one entry. An interrupt-return strobe restores all three on `ret_arith_o`, `ret_mode_o` and `ret_mask_o` one clock later.
- R3: A subroutine-return strobe without an interrupt strobe leaves the context store unchanged. Its three outputs and its status bits do not move.
- R4: A call strobe does not push the context store. A later interrupt return still yields the entry saved by the matching interrupt entry.
- R5: In `stk_status_o`, bit 0 is address-store empty, bit 1 is address-store overflow, bit 4 is context-store empty and bit 5 is context-store overflow. Bits 2, 3, 6 and 7 are always 0.
- R6: The address store holds 16 entries. A push onto a full address store sets bit 1, discards the data and keeps the depth. Bit 1 stays set until reset.
- R7: The context store holds 12 entries (parameter). A push onto a full context store sets bit 5 and discards the entry. Bit 5 stays set until reset.
- R8: A pop from an empty store drives that store's outputs to zero and leaves the store empty.
- R9: After reset, both empty bits are 1, both overflow bits are 0 and all popped-value outputs are 0.
- R10: A push and a pop on the same store in the same cycle pass the pushed value straight to that store's output and leave the store depth unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| call_i | input | 1 | Subroutine call strobe |
| irq_i | input | 1 | Interrupt entry strobe |
| rts_i | input | 1 | Subroutine return strobe |
| rti_i | input | 1 | Interrupt return strobe |
| pc_i | input | 14 | Return address to save |
| arith_i | input | 8 | Arithmetic flags to save |
| mode_i | input | 7 | Mode word to save |
| mask_i | input | 10 | Interrupt mask to save |
| ret_pc_o | output | 14 | Last popped return address |
| ret_arith_o | output | 8 | Last popped arithmetic flags |
| ret_mode_o | output | 7 | Last popped mode word |
| ret_mask_o | output | 10 | Last popped interrupt mask |
| stk_status_o | output | 8 | Read-only stack status byte |

## Verification
A wrong pointer shows up first in the status byte. That byte reflects the depth in the cycle after the offending strobe, with an empty bit set too early or too late. Corrupted storage or an off-by-one read index stays hidden until the affected level is popped. It then appears as a wrong value on the return outputs one clock after that pop. For this reason the bench pops every store completely and compares every value. A discarded overflow push is exposed only by popping a full store down to its oldest entry.

// File: rtl/stk_pkg.sv
// Package: shared types and fixed bit positions for the sequencer stacks.
// Assumes: status byte layout is fixed; widths below match the sequencer words.
package stk_pkg;

    localparam int unsigned PC_W    = 14;
    localparam int unsigned ARITH_W = 8;
    localparam int unsigned MODE_W  = 7;
    localparam int unsigned MASK_W  = 10;
    localparam int unsigned CTX_W   = ARITH_W + MODE_W + MASK_W;

    // Positions inside the stack status byte (behaviour: decoded by software)
    localparam int unsigned SB_PC_EMPTY  = 0;
    localparam int unsigned SB_PC_OVF    = 1;
    localparam int unsigned SB_CTX_EMPTY = 4;
    localparam int unsigned SB_CTX_OVF   = 5;

    // What a stack does on one clock
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_PASS,   // push and pop together: bypass
        ACT_PUSH,   // push into free slot
        ACT_DROP,   // push into full store: discarded
        ACT_POP,    // pop a stored entry
        ACT_UNDER   // pop of an empty store
    } stk_act_e;

    // One saved context entry
    typedef struct packed {
        logic [MASK_W-1:0]  mask;
        logic [MODE_W-1:0]  mode;
        logic [ARITH_W-1:0] arith;
    } ctx_entry_t;

endpackage

// File: rtl/lifo_core.sv
// Module: lifo_core
// Generic last-in-first-out store with a sticky overflow flag and a
// registered pop output. A push to a full store is discarded; a pop of an
// empty store outputs zero; push with pop bypasses the pushed word.
// Assumes: DEPTH >= 2; storage itself is not reset.
module lifo_core
    import stk_pkg::*;
#(
    parameter int unsigned W     = 14,
    parameter int unsigned DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         ovf_o
);

    localparam int unsigned PW = $clog2(DEPTH + 1);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr_q;
    logic          ovf_q;
    logic [W-1:0]  rdata_q;
    logic          full;
    logic          empty;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;
    logic [PW-1:0] ptr_dec;
    stk_act_e      act;

    // Purpose: derive level flags and slot indices from the pointer
    always_comb begin
        full    = (ptr_q == FULL_LVL);
        empty   = (ptr_q == '0);
        ptr_dec = ptr_q - PW'(1);
        wr_idx  = ptr_q[AW-1:0];
        rd_idx  = ptr_dec[AW-1:0];
    end

    // Purpose: classify this cycle's strobes into one stack action
    always_comb begin
        act = ACT_IDLE;
        if (push_i && pop_i) begin
            act = ACT_PASS;
        end else if (push_i) begin
            act = full ? ACT_DROP : ACT_PUSH;
        end else if (pop_i) begin
            act = empty ? ACT_UNDER : ACT_POP;
        end
    end

    // Purpose: write the pushed word into the next free slot
    always_ff @(posedge clk) begin
        if (act == ACT_PUSH) begin
            mem[wr_idx] <= wdata_i;
        end
    end

    // Purpose: update pointer, overflow flag and popped-value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            ovf_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            unique case (act)
                ACT_PASS:  rdata_q <= wdata_i;
                ACT_PUSH:  ptr_q   <= ptr_q + PW'(1);
                ACT_DROP:  ovf_q   <= 1'b1;
                ACT_POP: begin
                    rdata_q <= mem[rd_idx];
                    ptr_q   <= ptr_dec;
                end
                ACT_UNDER: rdata_q <= '0;
                default:   ;
            endcase
        end
    end

    assign rdata_o = rdata_q;
    assign empty_o = empty;
    assign ovf_o   = ovf_q;

    // Overflow flag is sticky until reset (R6, R7)
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // Depth never exceeds the configured entry count (R6, R7)
    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= FULL_LVL);

    // A push into a free slot raises the depth by one (R1)
    assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full) |=> (ptr_q == $past(ptr_q) + PW'(1)));

    // A full push changes nothing but raises overflow (R6)
    assert_drop_keeps_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full) |=> ($stable(ptr_q) && ovf_q));

    // Pop of empty store yields zero and stays empty (R8)
    assert_under_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty) |=> (rdata_o == '0 && empty_o));

    // Simultaneous push and pop bypass the pushed word (R10)
    assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (rdata_o == $past(wdata_i) && $stable(ptr_q)));

endmodule

// File: rtl/ctx_codec.sv
// Module: ctx_codec
// Packs the three status words into one context entry and splits a popped
// entry back into its fields. Pure wiring through the shared struct type.
// Assumes: field widths come from stk_pkg.
module ctx_codec
    import stk_pkg::*;
(
    input  logic [ARITH_W-1:0] arith_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [MASK_W-1:0]  mask_i,
    output logic [CTX_W-1:0]   packed_o,
    input  logic [CTX_W-1:0]   packed_i,
    output logic [ARITH_W-1:0] arith_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic [MASK_W-1:0]  mask_o
);

    ctx_entry_t enc;
    ctx_entry_t dec;

    // Purpose: assemble the entry to be saved
    always_comb begin
        enc.arith = arith_i;
        enc.mode  = mode_i;
        enc.mask  = mask_i;
        packed_o  = enc;
    end

    // Purpose: split a restored entry into its fields
    always_comb begin
        dec     = ctx_entry_t'(packed_i);
        arith_o = dec.arith;
        mode_o  = dec.mode;
        mask_o  = dec.mask;
    end

endmodule

// File: rtl/stat_byte_pack.sv
// Module: stat_byte_pack
// Places per-store empty and overflow flags at their fixed positions in
// the status byte; every other bit reads as zero.
// Assumes: positions from stk_pkg are distinct and below 8.
module stat_byte_pack
    import stk_pkg::*;
(
    input  logic       pc_empty_i,
    input  logic       pc_ovf_i,
    input  logic       ctx_empty_i,
    input  logic       ctx_ovf_i,
    output logic [7:0] status_o
);

    // Purpose: drive each bit from its flag, or zero when unused
    for (genvar b = 0; b < 8; b++) begin : g_bit
        if (b == SB_PC_EMPTY) begin : g_pe
            assign status_o[b] = pc_empty_i;
        end else if (b == SB_PC_OVF) begin : g_po
            assign status_o[b] = pc_ovf_i;
        end else if (b == SB_CTX_EMPTY) begin : g_ce
            assign status_o[b] = ctx_empty_i;
        end else if (b == SB_CTX_OVF) begin : g_co
            assign status_o[b] = ctx_ovf_i;
        end else begin : g_zero
            assign status_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/seq_return_stacks.sv
// Module: seq_return_stacks
// Return-address store and interrupt context store for a program sequencer.
// Calls and interrupt entries push the address; interrupt entries also push
// the context. Returns pop the address; interrupt returns also pop context.
// Assumes: strobes are single-cycle; pushes and pops of one kind per cycle.
module seq_return_stacks
    import stk_pkg::*;
#(
    parameter int unsigned PC_DEPTH  = 16,
    parameter int unsigned CTX_DEPTH = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               call_i,
    input  logic               irq_i,
    input  logic               rts_i,
    input  logic               rti_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [ARITH_W-1:0] arith_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [MASK_W-1:0]  mask_i,
    output logic [PC_W-1:0]    ret_pc_o,
    output logic [ARITH_W-1:0] ret_arith_o,
    output logic [MODE_W-1:0]  ret_mode_o,
    output logic [MASK_W-1:0]  ret_mask_o,
    output logic [7:0]         stk_status_o
);

    logic             pc_push;
    logic             pc_pop;
    logic             ctx_push;
    logic             ctx_pop;
    logic             pc_empty;
    logic             pc_ovf;
    logic             ctx_empty;
    logic             ctx_ovf;
    logic [CTX_W-1:0] ctx_wr;
    logic [CTX_W-1:0] ctx_rd;

    // Purpose: map control-flow events onto per-store push and pop
    always_comb begin
        pc_push  = call_i | irq_i;
        pc_pop   = rts_i | rti_i;
        ctx_push = irq_i;
        ctx_pop  = rti_i;
    end

    lifo_core #(.W(PC_W), .DEPTH(PC_DEPTH)) u_pc_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (pc_push),
        .pop_i   (pc_pop),
        .wdata_i (pc_i),
        .rdata_o (ret_pc_o),
        .empty_o (pc_empty),
        .ovf_o   (pc_ovf)
    );

    lifo_core #(.W(CTX_W), .DEPTH(CTX_DEPTH)) u_ctx_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (ctx_push),
        .pop_i   (ctx_pop),
        .wdata_i (ctx_wr),
        .rdata_o (ctx_rd),
        .empty_o (ctx_empty),
        .ovf_o   (ctx_ovf)
    );

    ctx_codec u_codec (
        .arith_i  (arith_i),
        .mode_i   (mode_i),
        .mask_i   (mask_i),
        .packed_o (ctx_wr),
        .packed_i (ctx_rd),
        .arith_o  (ret_arith_o),
        .mode_o   (ret_mode_o),
        .mask_o   (ret_mask_o)
    );

    stat_byte_pack u_sbyte (
        .pc_empty_i  (pc_empty),
        .pc_ovf_i    (pc_ovf),
        .ctx_empty_i (ctx_empty),
        .ctx_ovf_i   (ctx_ovf),
        .status_o    (stk_status_o)
    );

    // Subroutine return alone leaves the context store untouched (R3)
    assert_rts_keeps_ctx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_i && !rti_i && !irq_i) |=>
            ($stable({ret_arith_o, ret_mode_o, ret_mask_o}) &&
             $stable(stk_status_o[SB_CTX_OVF:SB_CTX_EMPTY])));

    // A call alone does not alter the context store level (R4)
    assert_call_keeps_ctx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !irq_i && !rti_i) |=> $stable(stk_status_o[SB_CTX_EMPTY]));

    // Unused status bits stay zero (R5)
    assert_spare_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_status_o[3:2] == 2'b00) && (stk_status_o[7:6] == 2'b00));

endmodule

// File: tb/test_seq_return_stacks.sv
`timescale 1ns/1ps
module test_seq_return_stacks;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0, irq_i = 1'b0, rts_i = 1'b0, rti_i = 1'b0;
    logic [13:0] pc_i = '0;
    logic [7:0]  arith_i = '0;
    logic [6:0]  mode_i = '0;
    logic [9:0]  mask_i = '0;
    logic [13:0] ret_pc_o;
    logic [7:0]  ret_arith_o;
    logic [6:0]  ret_mode_o;
    logic [9:0]  ret_mask_o;
    logic [7:0]  stk_status_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    seq_return_stacks i_seq_return_stacks (
        .clk(clk), .rst_n(rst_n),
        .call_i(call_i), .irq_i(irq_i), .rts_i(rts_i), .rti_i(rti_i),
        .pc_i(pc_i), .arith_i(arith_i), .mode_i(mode_i), .mask_i(mask_i),
        .ret_pc_o(ret_pc_o), .ret_arith_o(ret_arith_o), .ret_mode_o(ret_mode_o),
        .ret_mask_o(ret_mask_o), .stk_status_o(stk_status_o)
    );

    // op codes: 0 idle, 1 call, 2 irq, 3 rts, 4 rti
    typedef struct packed {
        logic [2:0]  op;
        logic [13:0] pc;
        logic [7:0]  ar;
        logic [6:0]  md;
        logic [9:0]  mk;
        logic [13:0] xpc;
        logic [7:0]  xar;
        logic [6:0]  xmd;
        logic [9:0]  xmk;
        logic [7:0]  xst;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd1, 14'h100, 8'h00, 7'h00, 10'h000, 14'h000, 8'h00, 7'h00, 10'h000, 8'h10}, // R1
        '{3'd2, 14'h200, 8'hA5, 7'h55, 10'h3C3, 14'h000, 8'h00, 7'h00, 10'h000, 8'h00}, // R2
        '{3'd1, 14'h300, 8'h11, 7'h22, 10'h033, 14'h000, 8'h00, 7'h00, 10'h000, 8'h00}, // R4
        '{3'd3, 14'h000, 8'h00, 7'h00, 10'h000, 14'h300, 8'h00, 7'h00, 10'h000, 8'h00}, // R3
        '{3'd4, 14'h000, 8'h00, 7'h00, 10'h000, 14'h200, 8'hA5, 7'h55, 10'h3C3, 8'h10}, // R2 R4
        '{3'd3, 14'h000, 8'h00, 7'h00, 10'h000, 14'h100, 8'hA5, 7'h55, 10'h3C3, 8'h11}, // R3
        '{3'd3, 14'h000, 8'h00, 7'h00, 10'h000, 14'h000, 8'hA5, 7'h55, 10'h3C3, 8'h11}, // R8
        '{3'd4, 14'h000, 8'h00, 7'h00, 10'h000, 14'h000, 8'h00, 7'h00, 10'h000, 8'h11}  // R8
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One strobe cycle, then outputs are settled at the following negedge
    task automatic step(input logic [2:0] op, input logic [13:0] pc,
                        input logic [7:0] ar, input logic [6:0] md, input logic [9:0] mk);
        @(negedge clk);
        call_i = (op == 3'd1); irq_i = (op == 3'd2);
        rts_i  = (op == 3'd3); rti_i = (op == 3'd4);
        pc_i = pc; arith_i = ar; mode_i = md; mask_i = mk;
        @(negedge clk);
        call_i = 1'b0; irq_i = 1'b0; rts_i = 1'b0; rti_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_reset_state();
        check("R9", "status after reset", 32'(stk_status_o), 32'h11);
        check("R9", "pc out after reset", 32'(ret_pc_o), 32'h0);
        check("R9", "context out after reset",
              32'({ret_arith_o, ret_mode_o, ret_mask_o}), 32'h0);
    endtask

    // Watchdog: a hung run counts as one failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check_reset_state();

        // Vector table: main push/pop behaviour
        for (int k = 0; k < 8; k++) begin
            step(VECS[k].op, VECS[k].pc, VECS[k].ar, VECS[k].md, VECS[k].mk);
            check("R1", $sformatf("vec %0d pc", k), 32'(ret_pc_o), 32'(VECS[k].xpc));
            check("R2", $sformatf("vec %0d arith", k), 32'(ret_arith_o), 32'(VECS[k].xar));
            check("R2", $sformatf("vec %0d mode", k), 32'(ret_mode_o), 32'(VECS[k].xmd));
            check("R2", $sformatf("vec %0d mask", k), 32'(ret_mask_o), 32'(VECS[k].xmk));
            check("R5", $sformatf("vec %0d status", k), 32'(stk_status_o), 32'(VECS[k].xst));
        end

        // R10: call and return together on an empty address store
        @(negedge clk);
        call_i = 1'b1; rts_i = 1'b1; pc_i = 14'h2AA;
        @(negedge clk);
        call_i = 1'b0; rts_i = 1'b0;
        check("R10", "bypass pc", 32'(ret_pc_o), 32'h2AA);
        check("R10", "bypass keeps depth", 32'(stk_status_o), 32'h11);

        // R6: fill the address store, overflow once, drain it
        for (int i = 0; i < 16; i++) step(3'd1, 14'(16'h10 + i), 8'h0, 7'h0, 10'h0);
        check("R6", "full, no overflow", 32'(stk_status_o), 32'h10);
        step(3'd1, 14'h3FF, 8'h0, 7'h0, 10'h0);
        check("R6", "overflow flag", 32'(stk_status_o), 32'h12);
        for (int i = 15; i >= 0; i--) begin
            step(3'd3, 14'h0, 8'h0, 7'h0, 10'h0);
            check("R6", $sformatf("drain level %0d", i), 32'(ret_pc_o), 32'(16'h10 + i));
        end
        check("R6", "empty with sticky overflow", 32'(stk_status_o), 32'h13);
        step(3'd3, 14'h0, 8'h0, 7'h0, 10'h0);
        check("R8", "pop past empty", 32'(ret_pc_o), 32'h0);

        // R9: reset clears overflow
        do_reset();
        @(negedge clk);
        check_reset_state();

        // R7: fill the context store, overflow once, drain it
        for (int i = 0; i < 12; i++)
            step(3'd2, 14'(16'h40 + i), 8'(i), 7'(i), 10'(i));
        check("R7", "context full", 32'(stk_status_o), 32'h00);
        step(3'd2, 14'h4C, 8'hEE, 7'h6E, 10'h2EE);
        check("R7", "context overflow", 32'(stk_status_o), 32'h20);
        for (int i = 11; i >= 0; i--) begin
            step(3'd4, 14'h0, 8'h0, 7'h0, 10'h0);
            check("R7", $sformatf("ctx level %0d", i),
                  32'({ret_arith_o, ret_mode_o, ret_mask_o}),
                  32'({8'(i), 7'(i), 10'(i)}));
            check("R1", $sformatf("pc level %0d", i), 32'(ret_pc_o),
                  32'(16'h41 + i));
        end
        check("R7", "context empty, sticky", 32'(stk_status_o), 32'h30);
        step(3'd4, 14'h0, 8'h0, 7'h0, 10'h0);
        check("R1", "oldest pc", 32'(ret_pc_o), 32'h40);
        check("R8", "context pop past empty",
              32'({ret_arith_o, ret_mode_o, ret_mask_o}), 32'h0);
        check("R5", "final status", 32'(stk_status_o), 32'h31);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule